// File: doc/BRIEF.md
# Message Rendezvous Tag Matcher

This block sits at the receiving node of a message-passing fabric and pairs announced sends with posted receives. A remote sender first sends a send-ready notice that carries its node number, a tag and a byte count. The block looks this notice up in a table of receives that local software has posted. If a receive matches, the block answers the sender at once with a receive-ready reply, and the bulk data can then move. If no receive matches, the block stores the notice in a pending-send table and sends nothing back, so the sender can go on computing. When a receive is posted later and matches a stored notice, the block sends a receive-ready request to that sender, which then pushes the data.

A posted receive names a source node, or any source through a wildcard flag, and gives a tag, a local buffer address and a buffer length. Both match orders are supported. Each match produces one message on a single valid/ready output stream, which carries a kind code, the remote node, the tag, the buffer address and the granted length. When that message is accepted, the table entry it consumed is freed, and a transfer-grant strobe goes to the local data mover in the same cycle.

Back-pressure works as follows. The output holds its message stable until out_ready is high. While a message is waiting, both input streams have ready low. A send-ready notice has priority over a receive post offered in the same cycle. A receive post is also held off when the posted table is full and no stored notice matches the post. The post port's ready therefore depends on the data it is offered.

Top module: `rdv_matcher`

## Requirements
- R1: After reset out_valid and grant_valid are low, and req_ready and post_ready are high.
- R2: A send-ready that matches a posted receive with an exact source emits out_kind 0 (reply). The message carries out_dst = sender, the tag, the posted buffer address, and out_len = the smaller of the two lengths.
- R3: A send-ready that matches no posted receive is stored without any output when the pending table has a free slot. A later post that matches it emits out_kind 1 (pull request) to the stored sender, with the post's address and the smaller length.
- R4: A wildcard receive (post_any = 1) matches a sender from any source that carries the same tag.
- R5: When a send-ready arrives, a posted receive with an exact source and tag match is chosen over a wildcard one.
- R6: When a wildcard post matches several stored send-ready notices, the one that arrived first is chosen.
- R7: A send-ready that matches nothing while the pending table is full emits out_kind 2 (refusal) to the sender, and nothing is stored.
- R8: While out_valid is high and out_ready is low, the output fields stay stable and req_ready and post_ready are low.
- R9: A matched table entry is freed in the cycle its output message is accepted. It does not match a second time.
- R10: When a send-ready and a post are offered in the same cycle, the send-ready is taken and post_ready is low.
- R11: A post that matches no stored send-ready is not accepted (post_ready low) while the posted table is full.
- R12: grant_valid is high exactly in cycles where an out_kind 0 or 1 message is accepted, and it carries that message's node, tag, address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Send-ready notice offered |
| req_ready | output | 1 | Send-ready notice accepted |
| req_src | input | SRC_W | Sender node |
| req_tag | input | TAG_W | Message tag |
| req_len | input | LEN_W | Bytes the sender offers |
| post_valid | input | 1 | Receive post offered |
| post_ready | output | 1 | Receive post accepted |
| post_any | input | 1 | Wildcard source |
| post_src | input | SRC_W | Expected source node |
| post_tag | input | TAG_W | Expected tag |
| post_addr | input | ADDR_W | Local buffer address |
| post_len | input | LEN_W | Buffer length |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Output message accepted |
| out_kind | output | 2 | 0 reply, 1 pull request, 2 refusal |
| out_dst | output | SRC_W | Remote node addressed |
| out_tag | output | TAG_W | Tag of the match |
| out_addr | output | ADDR_W | Local buffer address |
| out_len | output | LEN_W | Granted length |
| grant_valid | output | 1 | Transfer grant strobe |
| grant_node | output | SRC_W | Remote node of the transfer |
| grant_tag | output | TAG_W | Tag of the transfer |
| grant_addr | output | ADDR_W | Local buffer address |
| grant_len | output | LEN_W | Bytes to move |

## Verification
The bench builds the block with DEPTH = 4, two-bit node and tag fields, and four-bit address and length fields. These sizes let it sweep every source and tag pair through both match orders, with lengths chosen so that either side can be the shorter one. With only four slots per table it can also fill each table and reach the refusal path and the post stall. It can also stack several notices under one tag to check that the first arrival is served first, including after an entry in the middle of the order is removed.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  typedef enum logic [1:0] {
    K_REPLY = 2'd0,
    K_PULL  = 2'd1,
    K_NACK  = 2'd2
  } msg_kind_e;

  function automatic int unsigned idx_w(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/rdv_posted_tbl.sv
module rdv_posted_tbl #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8,
  localparam int unsigned IDX_W = rdv_pkg::idx_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_any,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [SRC_W-1:0]  q_src,
  input  logic [TAG_W-1:0]  q_tag,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [LEN_W-1:0]  hit_len,
  output logic              full
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] any_q;
  logic [SRC_W-1:0]  src_q  [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];

  logic             ex_hit, wc_hit;
  logic [IDX_W-1:0] ex_idx, wc_idx, free_idx;

  always_comb begin
    ex_hit = 1'b0; wc_hit = 1'b0;
    ex_idx = '0;   wc_idx = '0;
    free_idx = '0; full = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && tag_q[i] == q_tag) begin
        if (!any_q[i] && src_q[i] == q_src && !ex_hit) begin
          ex_hit = 1'b1; ex_idx = IDX_W'(i);
        end
        if (any_q[i] && !wc_hit) begin
          wc_hit = 1'b1; wc_idx = IDX_W'(i);
        end
      end
      if (!vld[i] && full) begin
        full = 1'b0; free_idx = IDX_W'(i);
      end
    end
    hit      = ex_hit | wc_hit;
    hit_idx  = ex_hit ? ex_idx : wc_idx;
    hit_addr = addr_q[hit_idx];
    hit_len  = len_q[hit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (clr_en) vld[clr_idx] <= 1'b0;
      if (wr_en)  vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      any_q[free_idx]  <= wr_any;
      src_q[free_idx]  <= wr_src;
      tag_q[free_idx]  <= wr_tag;
      addr_q[free_idx] <= wr_addr;
      len_q[free_idx]  <= wr_len;
    end
  end
endmodule

// File: rtl/rdv_pend_tbl.sv
module rdv_pend_tbl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SRC_W = 4,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned IDX_W = rdv_pkg::idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             q_any,
  input  logic [SRC_W-1:0] q_src,
  input  logic [TAG_W-1:0] q_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [SRC_W-1:0] hit_src,
  output logic [LEN_W-1:0] hit_len,
  output logic             full
);
  logic [DEPTH-1:0] vld;
  logic [SRC_W-1:0] src_q  [DEPTH];
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [LEN_W-1:0] len_q  [DEPTH];
  logic [IDX_W-1:0] rank_q [DEPTH];   // 0 = oldest live entry

  logic [IDX_W-1:0] free_idx, live_cnt;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_idx = '0; full = 1'b1; live_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && tag_q[i] == q_tag && (q_any || src_q[i] == q_src) &&
          (!hit || rank_q[i] < rank_q[hit_idx])) begin
        hit = 1'b1; hit_idx = IDX_W'(i);
      end
      if (!vld[i] && full) begin
        full = 1'b0; free_idx = IDX_W'(i);
      end
      if (vld[i]) live_cnt = live_cnt + 1'b1;
    end
    hit_src = src_q[hit_idx];
    hit_len = len_q[hit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) rank_q[i] <= '0;
    end else begin
      if (clr_en) begin
        vld[clr_idx] <= 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if (vld[i] && rank_q[i] > rank_q[clr_idx]) rank_q[i] <= rank_q[i] - 1'b1;
      end
      if (wr_en) begin
        vld[free_idx]    <= 1'b1;
        rank_q[free_idx] <= live_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_q[free_idx] <= wr_src;
      tag_q[free_idx] <= wr_tag;
      len_q[free_idx] <= wr_len;
    end
  end
endmodule

// File: rtl/rdv_matcher.sv
module rdv_matcher #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              post_valid,
  output logic              post_ready,
  input  logic              post_any,
  input  logic [SRC_W-1:0]  post_src,
  input  logic [TAG_W-1:0]  post_tag,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic [LEN_W-1:0]  post_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [SRC_W-1:0]  out_dst,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic              grant_valid,
  output logic [SRC_W-1:0]  grant_node,
  output logic [TAG_W-1:0]  grant_tag,
  output logic [ADDR_W-1:0] grant_addr,
  output logic [LEN_W-1:0]  grant_len
);
  import rdv_pkg::*;
  localparam int unsigned IDX_W = idx_w(DEPTH);

  logic              pt_hit, pt_full, pd_hit, pd_full;
  logic [IDX_W-1:0]  pt_idx, pd_idx, out_idx;
  logic [ADDR_W-1:0] pt_addr;
  logic [LEN_W-1:0]  pt_len, pd_len;
  logic [SRC_W-1:0]  pd_src;
  logic              acc_req, acc_post, fire;
  msg_kind_e         kind_q;

  function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a, b);
    return (a < b) ? a : b;
  endfunction

  assign req_ready  = !out_valid;
  assign post_ready = !out_valid && !req_valid && (pd_hit || !pt_full);
  assign acc_req    = req_valid && req_ready;
  assign acc_post   = post_valid && post_ready;
  assign fire       = out_valid && out_ready;
  assign out_kind   = kind_q;

  rdv_posted_tbl #(.DEPTH(DEPTH), .SRC_W(SRC_W), .TAG_W(TAG_W),
                   .ADDR_W(ADDR_W), .LEN_W(LEN_W)) posted_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_post && !pd_hit), .wr_any(post_any), .wr_src(post_src),
    .wr_tag(post_tag), .wr_addr(post_addr), .wr_len(post_len),
    .clr_en(fire && kind_q == K_REPLY), .clr_idx(out_idx),
    .q_src(req_src), .q_tag(req_tag),
    .hit(pt_hit), .hit_idx(pt_idx), .hit_addr(pt_addr), .hit_len(pt_len),
    .full(pt_full));

  rdv_pend_tbl #(.DEPTH(DEPTH), .SRC_W(SRC_W), .TAG_W(TAG_W),
                 .LEN_W(LEN_W)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_req && !pt_hit && !pd_full_q_gate()), .wr_src(req_src),
    .wr_tag(req_tag), .wr_len(req_len),
    .clr_en(fire && kind_q == K_PULL), .clr_idx(out_idx),
    .q_any(post_any), .q_src(post_src), .q_tag(post_tag),
    .hit(pd_hit), .hit_idx(pd_idx), .hit_src(pd_src), .hit_len(pd_len),
    .full(pd_full));

  function automatic logic pd_full_q_gate();
    return pd_full;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      kind_q    <= K_REPLY;
      out_dst   <= '0;
      out_tag   <= '0;
      out_addr  <= '0;
      out_len   <= '0;
      out_idx   <= '0;
    end else if (fire) begin
      out_valid <= 1'b0;
    end else if (acc_req && (pt_hit || pd_full)) begin
      out_valid <= 1'b1;
      kind_q    <= pt_hit ? K_REPLY : K_NACK;
      out_dst   <= req_src;
      out_tag   <= req_tag;
      out_addr  <= pt_hit ? pt_addr : '0;
      out_len   <= pt_hit ? len_min(req_len, pt_len) : '0;
      out_idx   <= pt_idx;
    end else if (acc_post && pd_hit) begin
      out_valid <= 1'b1;
      kind_q    <= K_PULL;
      out_dst   <= pd_src;
      out_tag   <= post_tag;
      out_addr  <= post_addr;
      out_len   <= len_min(post_len, pd_len);
      out_idx   <= pd_idx;
    end
  end

  assign grant_valid = fire && kind_q != K_NACK;
  assign grant_node  = out_dst;
  assign grant_tag   = out_tag;
  assign grant_addr  = out_addr;
  assign grant_len   = out_len;
endmodule

// File: rtl/rdv_matcher_chk.sv
module rdv_matcher_chk #(
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              post_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [SRC_W-1:0]  out_dst,
  input logic [TAG_W-1:0]  out_tag,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  out_len,
  input logic              grant_valid
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !grant_valid); // R1

  AST_HOLD_BLOCKS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready && !post_ready); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dst)
      && $stable(out_tag) && $stable(out_addr) && $stable(out_len)); // R8

  AST_REQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !post_ready); // R10

  AST_GRANT_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> out_valid && out_ready && out_kind != 2'd2); // R12

  AST_GRANT_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind != 2'd2 |-> grant_valid); // R12

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_kind != 2'd3); // R2
endmodule

bind rdv_matcher rdv_matcher_chk #(.SRC_W(SRC_W), .TAG_W(TAG_W),
                                   .ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .post_ready(post_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_kind(out_kind), .out_dst(out_dst), .out_tag(out_tag),
  .out_addr(out_addr), .out_len(out_len), .grant_valid(grant_valid));

// File: tb/rdv_matcher_tb_top.sv
`timescale 1ns/1ps
module rdv_matcher_tb_top;
  localparam int DEPTH = 4, SW = 2, TW = 2, AW = 4, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, post_valid = 0, post_any = 0, out_ready = 0;
  logic [SW-1:0] req_src = '0, post_src = '0;
  logic [TW-1:0] req_tag = '0, post_tag = '0;
  logic [LW-1:0] req_len = '0, post_len = '0;
  logic [AW-1:0] post_addr = '0;
  logic req_ready, post_ready, out_valid, grant_valid;
  logic [1:0] out_kind;
  logic [SW-1:0] out_dst, grant_node;
  logic [TW-1:0] out_tag, grant_tag;
  logic [AW-1:0] out_addr, grant_addr;
  logic [LW-1:0] out_len, grant_len;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  rdv_matcher #(.DEPTH(DEPTH), .SRC_W(SW), .TAG_W(TW), .ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_tag(req_tag), .req_len(req_len),
    .post_valid(post_valid), .post_ready(post_ready), .post_any(post_any),
    .post_src(post_src), .post_tag(post_tag), .post_addr(post_addr), .post_len(post_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_dst(out_dst),
    .out_tag(out_tag), .out_addr(out_addr), .out_len(out_len),
    .grant_valid(grant_valid), .grant_node(grant_node), .grant_tag(grant_tag),
    .grant_addr(grant_addr), .grant_len(grant_len));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int s, input int t, input int l);
    @(negedge clk);
    req_src = SW'(s); req_tag = TW'(t); req_len = LW'(l); req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic post(input bit any, input int s, input int t, input int a, input int l);
    @(negedge clk);
    post_any = any; post_src = SW'(s); post_tag = TW'(t);
    post_addr = AW'(a); post_len = LW'(l); post_valid = 1;
    #1;
    while (!post_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 post_valid = 0;
  endtask

  task automatic expect_out(input string req, input int k, input int d, input int t,
                            input int a, input int l);
    @(negedge clk);
    chk(out_valid == 1'b1, req, int'(out_valid), 1);
    chk(int'(out_kind) == k, req, int'(out_kind), k);
    chk(int'(out_dst) == d, req, int'(out_dst), d);
    chk(int'(out_tag) == t, req, int'(out_tag), t);
    if (k != 2) begin
      chk(int'(out_addr) == a, req, int'(out_addr), a);
      chk(int'(out_len) == l, req, int'(out_len), l);
    end
    out_ready = 1; #1;
    chk(grant_valid == (k != 2), "R12", int'(grant_valid), int'(k != 2));
    if (k != 2) begin
      chk(int'(grant_node) == d && int'(grant_addr) == a && int'(grant_len) == l &&
          int'(grant_tag) == t, "R12", int'(grant_addr), a);
    end
    @(posedge clk); #1 out_ready = 0;
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    chk(out_valid == 1'b0, req, int'(out_valid), 0);
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid && !grant_valid, "R1", int'(out_valid), 0);
    chk(req_ready && post_ready, "R1", int'(req_ready), 1);

    // R2 sweep: receive first, then send-ready
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        int ls, lp;
        ls = (s * 5 + t) % 16; lp = (t * 7 + s + 3) % 16;
        post(0, s, t, s * 4 + t, lp);
        expect_idle("R2");
        send(s, t, ls);
        expect_out("R2", 0, s, t, s * 4 + t, mn(ls, lp));
      end

    // R3/R4 sweep: send-ready first, then post (wildcard on odd tags)
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        int ls, lp;
        ls = (s * 3 + t * 5 + 1) % 16; lp = (s + t * 2 + 6) % 16;
        send(s, t, ls);
        expect_idle("R3");
        post(t[0], (t[0] ? (s + 1) % 4 : s), t, 15 - s * 4 - t, lp);
        expect_out(t[0] ? "R4" : "R3", 1, s, t, 15 - s * 4 - t, mn(ls, lp));
      end

    // R5: exact beats wildcard, wildcard serves other source
    post(1, 0, 1, 5, 9);
    post(0, 2, 1, 9, 9);
    send(2, 1, 3);
    expect_out("R5", 0, 2, 1, 9, 3);
    send(3, 1, 4);
    expect_out("R4", 0, 3, 1, 5, 4);

    // R6: oldest pending chosen by wildcard, also after mid removal
    send(1, 2, 1);
    send(3, 2, 2);
    send(0, 2, 3);
    post(0, 3, 2, 7, 15);
    expect_out("R6", 1, 3, 2, 7, 2);
    post(1, 0, 2, 8, 15);
    expect_out("R6", 1, 1, 2, 8, 1);
    send(2, 2, 4);
    post(1, 0, 2, 9, 15);
    expect_out("R6", 1, 0, 2, 9, 3);
    post(1, 0, 2, 10, 15);
    expect_out("R6", 1, 2, 2, 10, 4);

    // R7: pending full then refusal, then drain
    for (int t = 0; t < 4; t++) send(0, t, t + 1);
    expect_idle("R7");
    send(1, 0, 6);
    expect_out("R7", 2, 1, 0, 0, 0);
    for (int t = 0; t < 4; t++) begin
      post(0, 0, t, t, 15);
      expect_out("R7", 1, 0, t, t, t + 1);
    end
    post(1, 0, 0, 3, 3);   // would catch the refused notice if stored
    expect_idle("R7");
    send(2, 0, 2);
    expect_out("R7", 0, 2, 0, 3, 2);

    // R8: output held under back-pressure
    post(0, 1, 1, 3, 5);
    send(1, 1, 2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid && out_kind == 2'd0 && out_addr == 4'd3 && out_len == 4'd2,
          "R8", int'(out_addr), 3);
      chk(!req_ready && !post_ready, "R8", int'(req_ready), 0);
    end
    expect_out("R8", 0, 1, 1, 3, 2);

    // R9: matched posted entry freed, second send-ready is stored instead
    post(0, 1, 0, 6, 8);
    send(1, 0, 4);
    expect_out("R9", 0, 1, 0, 6, 4);
    send(1, 0, 5);
    expect_idle("R9");
    post(0, 1, 0, 12, 8);
    expect_out("R9", 1, 1, 0, 12, 5);

    // R10: simultaneous send-ready and post
    @(negedge clk);
    req_src = 2; req_tag = 3; req_len = 1; req_valid = 1;
    post_any = 0; post_src = 2; post_tag = 3; post_addr = 7; post_len = 2; post_valid = 1;
    #1;
    chk(req_ready == 1'b1, "R10", int'(req_ready), 1);
    chk(post_ready == 1'b0, "R10", int'(post_ready), 0);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk); #1;
    while (!post_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 post_valid = 0;
    expect_out("R10", 1, 2, 3, 7, 1);

    // R11: posted table full blocks an unmatched post
    for (int t = 0; t < 4; t++) post(0, 0, t, t + 4, 9);
    @(negedge clk);
    post_any = 0; post_src = 1; post_tag = 0; post_addr = 1; post_len = 1; post_valid = 1;
    #1 chk(post_ready == 1'b0, "R11", int'(post_ready), 0);
    @(negedge clk);
    #1 chk(post_ready == 1'b0, "R11", int'(post_ready), 0);
    post_valid = 0;
    for (int t = 0; t < 4; t++) begin
      send(0, t, 2);
      expect_out("R11", 0, 0, t, t + 4, 2);
    end
    expect_idle("R11");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule